// File: doc/BRIEF.md
# UART Dual-Counter Baud Generator

This block produces the bit-rate timing for an asynchronous serial port. A two-bit select picks the base tick from four sources: three fixed divisions of the system clock, or the rising edges of an external timer output. Two independent 5-bit channels count base ticks, one for transmit and one for receive. Each channel compares its count with a shared 5-bit divisor, reloads on a match, and halves the match rate in a toggle stage. Each channel emits one single-cycle enable pulse every second match.

Everything runs in one clock domain. The system clock serves as the prescaler clock, and all gating is done with synchronous enables. The transmit channel runs while the port is powered and transmit is enabled. A strobe marking the first transmit write re-phases it. The receive channel waits for a detected start bit, counts through the frame, and parks when the frame-done strobe arrives.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_baud` and `rx_baud` are 0.
- R2: `prs_sel` = 0, 1, 2 makes one base tick every 2, 8 and 32 clock cycles. After power-up the first base tick is counted on the 2nd, 8th or 32nd rising edge that samples `power_en` high.
- R3: `prs_sel` = 3 makes one base tick for each 0-to-1 change of `tmr_out`. Each rising change is counted on the following clock edge.
- R4: While `power_en` is 0 there are no base ticks, both outputs stay 0 and `tmr_out` edges are ignored. Powering up restarts the fixed-divider phase from zero.
- R5: While `power_en` or `tx_en` is 0 the transmit channel is held cleared. After it is enabled again, the first `tx_baud` pulse comes 2·D base ticks later, where D is the effective divisor.
- R6: A `tx_first_wr` pulse clears the transmit counter and its toggle stage on that edge. Any base tick on that edge is dropped, and the next pulse follows 2·D ticks later.
- R7: With `rx_en` and `power_en` high but no start bit detected, `rx_baud` stays 0.
- R8: A `rx_start_det` pulse clears and arms the receive channel. Its first pulse follows 2·D base ticks later, and pulses then repeat every 2·D ticks.
- R9: A `rx_frame_done` pulse clears and parks the receive channel. No further `rx_baud` pulse occurs until the next `rx_start_det`. A start pulse wins when both strobes arrive together.
- R10: The effective divisor D is `divisor` when it is 8 or more, and 8 otherwise.
- R11: Each baud output is a one-cycle pulse, and pulses on one output repeat every 2·D base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prs_sel | input | 2 | Base tick source: 0 /2, 1 /8, 2 /32, 3 timer edges |
| tmr_out | input | 1 | External timer output, synchronous to clk |
| power_en | input | 1 | Port power enable |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| divisor | input | 5 | Divisor D; values below 8 act as 8 |
| tx_first_wr | input | 1 | Strobe: first transmit word written |
| rx_start_det | input | 1 | Strobe: start bit detected |
| rx_frame_done | input | 1 | Strobe: receive frame finished |
| tx_baud | output | 1 | Transmit bit-rate enable pulse |
| rx_baud | output | 1 | Receive bit-rate enable pulse |

## Verification
The bench predicts the exact edge of every baud pulse and aims at phase errors. If `tx_first_wr` is ignored, a pulse lands 18 edges early. If disabling transmit fails to clear the channel, the pulse after re-enable comes at the wrong time. A prescaler that is not cleared at power-off shifts every later scenario. Receive tests cover a long idle with no start bit, a frame-done that must cut off the pulse due next, and a re-arm from an odd clock phase. Divisors 3 and 0 must behave exactly like 8, and timer-edge sourcing must count edges rather than high cycles.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    typedef enum logic [1:0] {
        SRC_DIV_A = 2'd0,
        SRC_DIV_B = 2'd1,
        SRC_DIV_C = 2'd2,
        SRC_TIMER = 2'd3
    } src_sel_e;

    localparam int NUM_CH = 2;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

endpackage

// File: rtl/ubg_base_sel.sv
module ubg_base_sel
    import ubg_pkg::*;
#(
    parameter int LOG_A = 1,
    parameter int LOG_B = 3,
    parameter int LOG_C = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       power_i,
    input  logic [1:0] sel_i,
    input  logic       tmr_i,
    output logic       tick_o
);

    localparam int MAX_AB = (LOG_A > LOG_B) ? LOG_A : LOG_B;
    localparam int PRE_W  = (MAX_AB > LOG_C) ? MAX_AB : LOG_C;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             tmr_prev;
    } base_st_t;

    base_st_t st_q, st_d;
    logic     src_tick;

    always_comb begin
        st_d          = st_q;
        st_d.tmr_prev = tmr_i;
        st_d.pre      = power_i ? st_q.pre + 1'b1 : '0;
    end

    always_comb begin
        unique case (src_sel_e'(sel_i))
            SRC_DIV_A: src_tick = &st_q.pre[LOG_A-1:0];
            SRC_DIV_B: src_tick = &st_q.pre[LOG_B-1:0];
            SRC_DIV_C: src_tick = &st_q.pre[LOG_C-1:0];
            default:   src_tick = tmr_i & ~st_q.tmr_prev;
        endcase
    end

    assign tick_o = power_i & src_tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a fresh power-up always starts the divider chain from zero
    a_r4_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_i) |-> (st_q.pre == '0));

    // R3: a timer level held high yields a single tick
    a_r3_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_i == SRC_TIMER) |=> (sel_i != SRC_TIMER || !tick_o));

endmodule

// File: rtl/ubg_channel.sv
module ubg_channel #(
    parameter int CNT_W   = 5,
    parameter int MIN_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             baud_o
);

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic             baud;
    } ch_st_t;

    ch_st_t           st_q, st_d;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] last_val;

    assign div_eff  = (div_i < MIN_V) ? MIN_V : div_i;
    assign last_val = div_eff - 1'b1;

    always_comb begin
        st_d      = st_q;
        st_d.baud = 1'b0;
        if (!run_i || clear_i) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else if (tick_i) begin
            if (st_q.cnt == last_val) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                st_d.baud = st_q.half;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_o = st_q.baud;

    // R11: enable output never stretches past one cycle
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        baud_o |=> !baud_o);

    // R6: a re-phase strobe suppresses the next output slot
    a_r6_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !baud_o);

    // R5: a stopped channel emits nothing
    a_r5_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !baud_o);

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import ubg_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int MIN_DIV = 8,
    parameter int LOG_A   = 1,
    parameter int LOG_B   = 3,
    parameter int LOG_C   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       prs_sel,
    input  logic             tmr_out,
    input  logic             power_en,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [CNT_W-1:0] divisor,
    input  logic             tx_first_wr,
    input  logic             rx_start_det,
    input  logic             rx_frame_done,
    output logic             tx_baud,
    output logic             rx_baud
);

    typedef struct packed {
        logic act;
    } rx_st_t;

    rx_st_t            rx_q, rx_d;
    logic              base_tick;
    logic              rx_live;
    logic [NUM_CH-1:0] ch_run;
    logic [NUM_CH-1:0] ch_clear;
    logic [NUM_CH-1:0] ch_baud;

    ubg_base_sel #(
        .LOG_A (LOG_A),
        .LOG_B (LOG_B),
        .LOG_C (LOG_C)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .power_i (power_en),
        .sel_i   (prs_sel),
        .tmr_i   (tmr_out),
        .tick_o  (base_tick)
    );

    assign rx_live = power_en & rx_en;

    always_comb begin
        rx_d = rx_q;
        if (!rx_live) begin
            rx_d.act = 1'b0;
        end else if (rx_start_det) begin
            rx_d.act = 1'b1;
        end else if (rx_frame_done) begin
            rx_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign ch_run[CH_TX]   = power_en & tx_en;
    assign ch_clear[CH_TX] = tx_first_wr;
    assign ch_run[CH_RX]   = rx_live & rx_q.act;
    assign ch_clear[CH_RX] = rx_start_det | rx_frame_done;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ubg_channel #(
            .CNT_W   (CNT_W),
            .MIN_DIV (MIN_DIV)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (ch_run[g]),
            .clear_i (ch_clear[g]),
            .tick_i  (base_tick),
            .div_i   (divisor),
            .baud_o  (ch_baud[g])
        );
    end

    assign tx_baud = ch_baud[CH_TX];
    assign rx_baud = ch_baud[CH_RX];

    // R4: an unpowered port stays silent on both outputs
    a_r4_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en |=> (!tx_baud && !rx_baud));

    // R7: the receive output is quiet whenever no frame is in progress
    a_r7_rx_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_q.act |-> !rx_baud);

    // R9: a frame-done strobe without a start parks the receiver
    a_r9_done_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done && !rx_start_det) |=> !rx_q.act);

endmodule

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] prs_sel = 2'd0;
    logic       tmr_out = 1'b0;
    logic       power_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [4:0] divisor = 5'd8;
    logic       tx_first_wr = 1'b0;
    logic       rx_start_det = 1'b0;
    logic       rx_frame_done = 1'b0;
    logic       tx_baud;
    logic       rx_baud;

    int n_chk = 0;
    int n_bad = 0;
    int ecount = 0;
    int tx_seen = 0;
    int rx_seen = 0;
    int stretch = 0;
    logic tx_prev = 1'b0;
    logic rx_prev = 1'b0;
    bit done_flag = 1'b0;

    int    txq[$];
    string txt[$];
    int    rxq[$];
    string rxt[$];

    uart_baud_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .prs_sel       (prs_sel),
        .tmr_out       (tmr_out),
        .power_en      (power_en),
        .tx_en         (tx_en),
        .rx_en         (rx_en),
        .divisor       (divisor),
        .tx_first_wr   (tx_first_wr),
        .rx_start_det  (rx_start_det),
        .rx_frame_done (rx_frame_done),
        .tx_baud       (tx_baud),
        .rx_baud       (rx_baud)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_tx(input int e, input string tag);
        txq.push_back(e);
        txt.push_back(tag);
    endtask

    task automatic push_rx(input int e, input string tag);
        rxq.push_back(e);
        rxt.push_back(tag);
    endtask

    // monitor: compares observed pulse edges with scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_baud && tx_prev) stretch++;
            if (rx_baud && rx_prev) stretch++;
            if (tx_baud) begin
                tx_seen++;
                if (txq.size() == 0) begin
                    chk(1'b0, "R5 unexpected tx pulse", ecount, -1);
                end else begin
                    chk(txq[0] == ecount, txt[0], ecount, txq[0]);
                    void'(txq.pop_front());
                    void'(txt.pop_front());
                end
            end
            if (rx_baud) begin
                rx_seen++;
                if (rxq.size() == 0) begin
                    chk(1'b0, "R9 unexpected rx pulse", ecount, -1);
                end else begin
                    chk(rxq[0] == ecount, rxt[0], ecount, rxq[0]);
                    void'(rxq.pop_front());
                    void'(rxt.pop_front());
                end
            end
            tx_prev <= tx_baud;
            rx_prev <= rx_baud;
        end
    end

    task automatic wait_until(input int e);
        while (ecount < e) @(negedge clk);
    endtask

    task automatic power_up(input logic [1:0] s, input logic [4:0] d,
                            input logic te, input logic re, output int b);
        @(negedge clk);
        prs_sel  = s;
        divisor  = d;
        tx_en    = te;
        rx_en    = re;
        power_en = 1'b1;
        b        = ecount;
    endtask

    task automatic shut_down();
        @(negedge clk);
        power_en = 1'b0;
        tx_en    = 1'b0;
        rx_en    = 1'b0;
        tmr_out  = 1'b0;
        repeat (3) @(negedge clk);
        while (txq.size() > 0) begin
            chk(1'b0, {txt[0], " missing tx pulse"}, -1, txq[0]);
            void'(txq.pop_front());
            void'(txt.pop_front());
        end
        while (rxq.size() > 0) begin
            chk(1'b0, {rxt[0], " missing rx pulse"}, -1, rxq[0]);
            void'(rxq.pop_front());
            void'(rxt.pop_front());
        end
    endtask

    task automatic fixed_case(input logic [1:0] s, input logic [4:0] d,
                              input int per, input int span, input string tag);
        int b;
        power_up(s, d, 1'b1, 1'b0, b);
        for (int n = 1; 2 * n * per <= span; n++) push_tx(b + 2 * n * per, tag);
        wait_until(b + span);
        shut_down();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int b;
        int s0;
        int r0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(tx_baud == 1'b0 && rx_baud == 1'b0, "R1 in reset", {tx_baud, rx_baud}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_baud == 1'b0 && rx_baud == 1'b0, "R1 after reset", {tx_baud, rx_baud}, 0);

        // R4: unpowered, with enables, strobes and timer activity
        prs_sel = 2'd3; tx_en = 1'b1; rx_en = 1'b1; divisor = 5'd8;
        s0 = tx_seen; r0 = rx_seen;
        rx_start_det = 1'b1; @(negedge clk); rx_start_det = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tmr_out = 1'b1; @(negedge clk);
            tmr_out = 1'b0; repeat (2) @(negedge clk);
        end
        chk(tx_seen == s0, "R4 tx silent unpowered", tx_seen - s0, 0);
        chk(rx_seen == r0, "R4 rx silent unpowered", rx_seen - r0, 0);
        tx_en = 1'b0; rx_en = 1'b0;

        // R2: the three fixed dividers and a large divisor
        fixed_case(2'd0, 5'd10, 20, 125, "R2 div2 D10");
        fixed_case(2'd1, 5'd8, 64, 260, "R2 div8 D8");
        fixed_case(2'd2, 5'd8, 256, 1030, "R2 div32 D8");
        fixed_case(2'd0, 5'd31, 62, 250, "R11 div2 D31");

        // R10: reserved divisors act as 8
        fixed_case(2'd0, 5'd3, 16, 100, "R10 D3 as 8");
        fixed_case(2'd0, 5'd0, 16, 100, "R10 D0 as 8");

        // R3: timer edge source, high 2 cycles of every 5
        power_up(2'd3, 5'd8, 1'b1, 1'b0, b);
        push_tx(b + 78, "R3 timer tick 16");
        push_tx(b + 158, "R3 timer tick 32");
        for (int i = 0; i < 40; i++) begin
            wait_until(b + 5 * i + 2); tmr_out = 1'b1;
            wait_until(b + 5 * i + 4); tmr_out = 1'b0;
        end
        shut_down();

        // R6: first-write strobe re-phases transmit
        power_up(2'd0, 5'd8, 1'b1, 1'b0, b);
        push_tx(b + 32, "R6 before restart");
        wait_until(b + 49);
        tx_first_wr = 1'b1; @(negedge clk); tx_first_wr = 1'b0;
        push_tx(b + 82, "R6 after restart");
        push_tx(b + 114, "R6 second after restart");
        wait_until(b + 120);
        shut_down();

        // R5: transmit enable drop clears the channel
        power_up(2'd0, 5'd8, 1'b1, 1'b0, b);
        push_tx(b + 32, "R5 before disable");
        wait_until(b + 40); tx_en = 1'b0;
        wait_until(b + 59); tx_en = 1'b1;
        push_tx(b + 90, "R5 after re-enable");
        push_tx(b + 122, "R5 second after re-enable");
        wait_until(b + 125);
        shut_down();

        // R7 R8 R9: receive idle, start, frame done, re-arm
        s0 = tx_seen;
        power_up(2'd0, 5'd9, 1'b0, 1'b1, b);
        r0 = rx_seen;
        wait_until(b + 99);
        chk(rx_seen == r0, "R7 rx idle without start", rx_seen - r0, 0);
        rx_start_det = 1'b1; @(negedge clk); rx_start_det = 1'b0;
        push_rx(b + 136, "R8 first rx pulse");
        push_rx(b + 172, "R8 second rx pulse");
        wait_until(b + 179);
        rx_frame_done = 1'b1; @(negedge clk); rx_frame_done = 1'b0;
        wait_until(b + 260);
        chk(rx_seen - r0 == 2, "R9 rx parked after frame", rx_seen - r0, 2);
        rx_start_det = 1'b1; @(negedge clk); rx_start_det = 1'b0;
        push_rx(b + 296, "R8 re-armed rx pulse");
        wait_until(b + 300);
        shut_down();
        chk(tx_seen == s0, "R5 tx silent while disabled", tx_seen - s0, 0);

        // R9: simultaneous start and done keeps the receiver armed
        power_up(2'd0, 5'd8, 1'b0, 1'b1, b);
        wait_until(b + 9);
        rx_start_det = 1'b1; rx_frame_done = 1'b1; @(negedge clk);
        rx_start_det = 1'b0; rx_frame_done = 1'b0;
        push_rx(b + 42, "R9 start wins over done");
        wait_until(b + 50);
        shut_down();

        chk(stretch == 0, "R11 one-cycle pulses", stretch, 0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule